// File: doc/BRIEF.md
# Daisy-Chained Interrupt Vector Responder

This block is the interrupt logic of one peripheral that sits in a priority daisy chain of devices. Internal sources pulse their raise inputs to set pending bits. Each source has an enable bit, and any enabled pending bit pulls the active-low request line. Priority between devices comes from a serial chain. A device may answer an acknowledge only while its enable-in is high. Its enable-out is high only while its enable-in is high and it is neither under service nor, during an acknowledge, requesting.

The acknowledge input is sampled on the rising clock edge. At the first edge where it is seen active, the block records whether it has an eligible request and which source is the highest-priority one. While the acknowledge is held, a low read strobe puts the 8-bit vector on the data bus, but only if enable-in is high and a request was recorded. The bus is modelled as a data value plus an output-enable. The clock edge after the vector is first driven marks that source as under service and drops its pending bit. A one-cycle clear pulse, issued on return from the handler, removes the highest-priority under-service mark. Within the device, only sources of strictly higher priority than the highest one under service may claim a new acknowledge. The acknowledging read involves no chip select.

Top module: `dcir_responder`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, all pending and under-service state is cleared. After reset, `irq_n` is 1, `vec_oe` is 0 and `eo` equals `ei`.
- R2: `irq_n` is 0 exactly when some source `i` has `pend[i]` set and `src_en[i]` is 1. A source with `src_en[i]=0` does not pull the request, but its pending bit is kept. A `raise[i]` pulse at an edge sets `pend[i]`.
- R3: Outside an acknowledge cycle, `eo` is 1 exactly when `ei` is 1 and no source is under service. Pending requests have no effect on `eo` there.
- R4: `ack_n` is sampled at the rising edge. From the first edge where it is seen low, `eo` is 0 if an eligible request was captured at that edge. With no eligible request and nothing under service, `eo` keeps following `ei` during the acknowledge.
- R5: `vec_oe` is 1 only while a sampled acknowledge is active, `rd_n` is 0, `ei` is 1 and a request was captured. Otherwise the bus stays undriven. This includes a read with no acknowledge and an acknowledge with `ei` low.
- R6: With `code_en`=0, `vec_out` equals `vec_base`. With `code_en`=1, `vec_out` is `{vec_base[7:3], code}`, where `code` is the index of the lowest-numbered eligible source at the capture edge. Source 0 has the highest priority.
- R7: At the first clock edge with `vec_oe` high, the captured source's under-service mark is set and its pending bit is cleared. `eo` then stays 0 until that mark is cleared.
- R8: A `ius_clr` pulse at an edge clears only the lowest-numbered (highest-priority) under-service mark.
- R9: While source `k` is under service, only sources with index below `k` are eligible. A pending source with a higher index neither claims the acknowledge nor drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| raise | input | NSRC | One-cycle pulses that set pending bits |
| src_en | input | NSRC | Per-source request enable (1 = enabled) |
| vec_base | input | 8 | Programmed vector value |
| code_en | input | 1 | Replace vector bits 2:0 with the source code |
| ack_n | input | 1 | Interrupt acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| ei | input | 1 | Chain enable-in from the higher-priority device |
| ius_clr | input | 1 | Return-from-interrupt pulse that clears the highest under-service mark |
| irq_n | output | 1 | Interrupt request, active low |
| eo | output | 1 | Chain enable-out to the lower-priority device |
| vec_out | output | 8 | Vector value on the bus |
| vec_oe | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The embedded properties are checked on every cycle. They cover these points: a drive needs enable-in and forces enable-out low, enable-out never rises without enable-in, and a new under-service mark appears only after a service edge. They also check that a clear pulse removes exactly one mark, that reset empties all state, and that the vector holds steady while driven. Some behaviours need the directed scenarios to show them. These are the exact vector values with and without the source code, the choice of the highest-priority eligible source, and the nesting rule that blocks lower-priority sources while a higher one is in service. The same holds for the way a disabled source keeps its pending bit, and for the chain outcome when enable-in is low during an acknowledge.

// File: rtl/dcir_pkg.sv
package dcir_pkg;
  localparam int VEC_W  = 8;
  localparam int CODE_W = 3;
  typedef logic [VEC_W-1:0]  vec_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/dcir_prio_pick.sv
module dcir_prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]          req,
  output logic                  found,
  output dcir_pkg::code_t       code,
  output logic [N-1:0]          onehot
);
  logic [N-1:0] lower_any;

  assign lower_any[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < N; g++) begin : g_prefix
      assign lower_any[g] = lower_any[g-1] | req[g-1];
    end
  endgenerate

  assign onehot = req & ~lower_any;
  assign found  = |req;

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) code = code | dcir_pkg::code_t'(i);
    end
  end
endmodule

// File: rtl/dcir_src_state.sv
module dcir_src_state #(
  parameter int N = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          raise,
  input  logic                  svc_go,
  input  dcir_pkg::code_t       svc_code,
  input  logic                  ius_clr,
  output logic [N-1:0]          pend,
  output logic [N-1:0]          ius
);
  logic [N-1:0]    svc_mask;
  logic [N-1:0]    ius_top;
  logic            ius_found;
  dcir_pkg::code_t ius_code;

  always_comb begin
    svc_mask = '0;
    for (int i = 0; i < N; i++) begin
      if (svc_go && (dcir_pkg::code_t'(i) == svc_code)) svc_mask[i] = 1'b1;
    end
  end

  dcir_prio_pick #(.N(N)) u_ius_pick (
    .req    (ius),
    .found  (ius_found),
    .code   (ius_code),
    .onehot (ius_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      ius  <= '0;
    end else begin
      pend <= (pend & ~svc_mask) | raise;
      ius  <= (ius & ~(ius_clr ? ius_top : '0)) | svc_mask;
    end
  end

  // R1: reset leaves no pending or under-service state
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (pend == '0 && ius == '0));

  // R7: a new under-service mark only follows a service edge
  assert_ius_needs_service_R7: assert property (@(posedge clk) disable iff (rst)
    ((ius & ~$past(ius)) != '0) |-> $past(svc_go));

  // R8: a clear pulse without a service removes exactly one mark
  assert_clear_one_mark_R8: assert property (@(posedge clk) disable iff (rst)
    (ius_clr && ius_found && !svc_go) |=> ($countones(ius) == $countones($past(ius)) - 1));
endmodule

// File: rtl/dcir_ack_ctrl.sv
module dcir_ack_ctrl (
  input  logic            clk,
  input  logic            rst,
  input  logic            ack_n,
  input  logic            rd_n,
  input  logic            ei,
  input  logic            cand_any,
  input  dcir_pkg::code_t cand_code,
  input  logic            ius_any,
  output logic            eo,
  output logic            bus_oe,
  output logic            svc_go,
  output dcir_pkg::code_t cap_code
);
  logic ack_q;
  logic req_cap;
  logic svc_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q    <= 1'b0;
      req_cap  <= 1'b0;
      svc_done <= 1'b0;
      cap_code <= '0;
    end else begin
      ack_q <= ~ack_n;
      if (!ack_q && !ack_n) begin
        req_cap  <= cand_any;
        cap_code <= cand_code;
      end else if (ack_n) begin
        req_cap <= 1'b0;
      end
      if (ack_n)       svc_done <= 1'b0;
      else if (svc_go) svc_done <= 1'b1;
    end
  end

  assign bus_oe = ack_q & ~rd_n & ei & req_cap;
  assign svc_go = bus_oe & ~svc_done;
  assign eo     = ei & ~ius_any & ~(ack_q & req_cap);

  // R5: the bus is only driven with the chain enable present
  assert_drive_needs_ei_R5: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> ei);

  // R4: a device driving its vector blocks the lower chain
  assert_drive_blocks_chain_R4: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !eo);
endmodule

// File: rtl/dcir_responder.sv
module dcir_responder #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] raise,
  input  logic [NSRC-1:0] src_en,
  input  logic [7:0]      vec_base,
  input  logic            code_en,
  input  logic            ack_n,
  input  logic            rd_n,
  input  logic            ei,
  input  logic            ius_clr,
  output logic            irq_n,
  output logic            eo,
  output logic [7:0]      vec_out,
  output logic            vec_oe
);
  localparam int CW = dcir_pkg::CODE_W;

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] ius;
  logic [NSRC-1:0] active;
  logic [NSRC-1:0] blocked;
  logic [NSRC-1:0] eligible;
  logic [NSRC-1:0] elig_onehot;
  logic            elig_any;
  dcir_pkg::code_t elig_code;
  dcir_pkg::code_t cap_code;
  dcir_pkg::code_t svc_code;
  logic            svc_go;

  assign active = pend & src_en;
  assign irq_n  = ~(|active);

  // a source is blocked when it or any higher-priority source is under service
  assign blocked[0] = ius[0];
  genvar g;
  generate
    for (g = 1; g < NSRC; g++) begin : g_block
      assign blocked[g] = blocked[g-1] | ius[g];
    end
  endgenerate
  assign eligible = active & ~blocked;

  dcir_prio_pick #(.N(NSRC)) u_elig_pick (
    .req    (eligible),
    .found  (elig_any),
    .code   (elig_code),
    .onehot (elig_onehot)
  );

  dcir_ack_ctrl u_ack (
    .clk       (clk),
    .rst       (rst),
    .ack_n     (ack_n),
    .rd_n      (rd_n),
    .ei        (ei),
    .cand_any  (elig_any),
    .cand_code (elig_code),
    .ius_any   (|ius),
    .eo        (eo),
    .bus_oe    (vec_oe),
    .svc_go    (svc_go),
    .cap_code  (cap_code)
  );

  assign svc_code = cap_code;

  dcir_src_state #(.N(NSRC)) u_state (
    .clk      (clk),
    .rst      (rst),
    .raise    (raise),
    .svc_go   (svc_go),
    .svc_code (svc_code),
    .ius_clr  (ius_clr),
    .pend     (pend),
    .ius      (ius)
  );

  assign vec_out = code_en ? {vec_base[7:CW], cap_code} : vec_base;

  // R3: the chain is never enabled downstream without enable-in
  assert_eo_needs_ei_R3: assert property (@(posedge clk) disable iff (rst)
    eo |-> ei);

  // R6: the vector holds steady while it is being driven
  assert_vector_steady_R6: assert property (@(posedge clk) disable iff (rst)
    (vec_oe && $past(vec_oe) && $stable(vec_base) && $stable(code_en)) |-> $stable(vec_out));
endmodule

// File: tb/tb_dcir_responder.sv
module tb_dcir_responder;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] raise;
  logic [N-1:0] src_en;
  logic [7:0]   vec_base;
  logic         code_en;
  logic         ack_n;
  logic         rd_n;
  logic         ei;
  logic         ius_clr;
  logic         irq_n;
  logic         eo;
  logic [7:0]   vec_out;
  logic         vec_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dcir_responder #(.NSRC(N)) dut (
    .clk(clk), .rst(rst), .raise(raise), .src_en(src_en),
    .vec_base(vec_base), .code_en(code_en), .ack_n(ack_n), .rd_n(rd_n),
    .ei(ei), .ius_clr(ius_clr), .irq_n(irq_n), .eo(eo),
    .vec_out(vec_out), .vec_oe(vec_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic raise_src(input int k);
    raise[k] = 1'b1;
    tick();
    raise = '0;
  endtask

  task automatic clear_pulse();
    ius_clr = 1'b1;
    tick();
    ius_clr = 1'b0;
  endtask

  // full acknowledge cycle; reports eo during ack and the driven vector
  task automatic ack_cycle(output bit eo_ack, output bit oe, output logic [7:0] v);
    ack_n = 1'b0;
    tick();
    eo_ack = eo;
    rd_n = 1'b0;
    #1;
    oe = vec_oe;
    v = vec_out;
    tick();
    rd_n = 1'b1;
    ack_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; ei = 1'b1;
    tick(); tick();
    rst = 1'b0;
    #1;
    chk(irq_n == 1'b1, "R1 irq_n after reset", irq_n, 1);
    chk(vec_oe == 1'b0, "R1 vec_oe after reset", vec_oe, 0);
    chk(eo == 1'b1, "R1 eo follows ei high", eo, 1);
    ei = 1'b0; #1;
    chk(eo == 1'b0, "R1 eo follows ei low", eo, 0);
    ei = 1'b1; #1;
  endtask

  task automatic t_request();
    src_en = 8'hF7;
    raise_src(3);
    chk(irq_n == 1'b1, "R2 disabled source no request", irq_n, 1);
    src_en = 8'hFF; #1;
    chk(irq_n == 1'b0, "R2 pending kept and requests once enabled", irq_n, 0);
    chk(eo == 1'b1, "R3 pending ignored outside ack", eo, 1);
    rd_n = 1'b0; #1;
    chk(vec_oe == 1'b0, "R5 read without ack not driven", vec_oe, 0);
    rd_n = 1'b1;
    src_en = 8'hF7; #1;
  endtask

  task automatic t_plain_vector();
    bit e, o; logic [7:0] v;
    code_en = 1'b0;
    raise_src(4);
    ack_cycle(e, o, v);
    chk(e == 1'b0, "R4 eo low during claimed ack", e, 0);
    chk(o == 1'b1, "R5 vector driven", o, 1);
    chk(v == 8'hA5, "R6 plain vector", v, 8'hA5);
    chk(irq_n == 1'b1, "R7 pending dropped after service", irq_n, 1);
    chk(eo == 1'b0, "R7 eo low while under service", eo, 0);
    clear_pulse();
    chk(eo == 1'b1, "R8 clear restores eo", eo, 1);
  endtask

  task automatic t_nesting();
    bit e, o; logic [7:0] v;
    code_en = 1'b1;
    raise[2] = 1'b1; raise[6] = 1'b1;
    tick(); raise = '0;
    ack_cycle(e, o, v);
    chk(v == 8'hA2, "R6 coded vector picks source 2", v, 8'hA2);
    chk(irq_n == 1'b0, "R2 source 6 still requests", irq_n, 0);
    ack_cycle(e, o, v);
    chk(o == 1'b0, "R9 lower source 6 blocked by service of 2", o, 0);
    raise_src(1);
    ack_cycle(e, o, v);
    chk(o == 1'b1 && v == 8'hA1, "R9 higher source 1 nests", {o, v}, {1'b1, 8'hA1});
    clear_pulse();
    chk(eo == 1'b0, "R8 one clear leaves source 2 in service", eo, 0);
    ack_cycle(e, o, v);
    chk(o == 1'b0, "R8 source 2 still blocks source 6", o, 0);
    clear_pulse();
    chk(eo == 1'b1, "R8 second clear frees chain", eo, 1);
    ack_cycle(e, o, v);
    chk(o == 1'b1 && v == 8'hA6, "R6 coded vector source 6", {o, v}, {1'b1, 8'hA6});
    clear_pulse();
  endtask

  task automatic t_chain_low();
    bit e, o; logic [7:0] v;
    raise_src(5);
    ei = 1'b0;
    ack_cycle(e, o, v);
    chk(o == 1'b0, "R5 ei low keeps bus undriven", o, 0);
    chk(e == 1'b0, "R4 eo low with ei low", e, 0);
    chk(irq_n == 1'b0, "R7 no service when not driven", irq_n, 0);
    ei = 1'b1; #1;
    ack_cycle(e, o, v);
    chk(o == 1'b1 && v == 8'hA5, "R6 source 5 served after ei returns", {o, v}, {1'b1, 8'hA5});
    clear_pulse();
  endtask

  task automatic t_idle_ack();
    bit e, o; logic [7:0] v;
    ack_cycle(e, o, v);
    chk(e == 1'b1, "R4 eo follows ei with no request", e, 1);
    chk(o == 1'b0, "R5 no drive without request", o, 0);
  endtask

  task automatic t_reset_mid();
    raise_src(0);
    ack_n = 1'b0; tick();
    rst = 1'b1; tick(); rst = 1'b0; ack_n = 1'b1; #1;
    chk(irq_n == 1'b1 && eo == 1'b1, "R1 reset clears request and chain", {irq_n, eo}, 2'b11);
  endtask

  initial begin
    rst = 1'b1; raise = '0; src_en = 8'hFF; vec_base = 8'hA5; code_en = 1'b0;
    ack_n = 1'b1; rd_n = 1'b1; ei = 1'b1; ius_clr = 1'b0;
    t_reset();
    t_request();
    t_plain_vector();
    t_nesting();
    t_chain_low();
    t_idle_ack();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule